// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block tracks the position of an incremental shaft encoder from its two phase signals, I and Q. Both inputs are looked at only on a sampling strobe that comes from an outside prescaler. Each input goes through a two-sample glitch filter. The filtered pair drives an up/down position counter that moves by one on every legal Gray-code step. The direction comes from which phase leads.

When the counter wraps, a sticky flag is set: one flag for wrapping upward and one for wrapping downward. An interrupt line stays high while either flag is set. A one-cycle read strobe clears both flags and the interrupt. While the enable is low, the decoder keeps following the filtered input state but does not count. Because of that, switching the enable on or off can never cause a count.

Top module: `quad_pos_tracker`

## Requirements
- R1: After reset, `pos` is 0, both `stat` bits are 0 and `irq` is 0.
- R2: With the phase pair written as {I,Q}, the forward order is 00, 10, 11, 01, then back to 00 (I leads Q). Each single step in this order increments `pos` by one. The new value appears on the second clock edge after the strobe that accepts the new level.
- R3: Each single step in the reverse order (00, 01, 11, 10) decrements `pos` by one.
- R4: An input level passes the filter only after two consecutive strobe samples have seen it. A level that is present for only one strobe sample never changes `pos`.
- R5: The inputs are sampled only in cycles where `tick` is 1. Input changes that come and go between strobes have no effect on `pos`.
- R6: If both filtered phases change in the same sample, the step is illegal and `pos` does not change. The new pair then becomes the reference for the next step.
- R7: An increment from FFh to 00h sets `stat[0]`. A decrement from 00h to FFh sets `stat[1]`. `irq` is 1 whenever either bit is set.
- R8: A one-cycle pulse on `stat_rd` clears both `stat` bits, and with them `irq`, on the next clock edge.
- R9: While `en` is 0, `pos` holds its value and the reference still follows the filtered inputs. Raising or lowering `en` never changes `pos`, and the first step after re-enabling is measured from the pair present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling strobe from the prescaler, at most every other cycle |
| en | input | 1 | Counting enable |
| in_i | input | 1 | In-phase encoder input |
| in_q | input | 1 | Quadrature encoder input |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| pos | output | 8 | Position counter |
| stat | output | 2 | Sticky flags: bit 0 upward wrap, bit 1 downward wrap |
| irq | output | 1 | Wrap interrupt, high while any flag is set |

## Verification
The bench drives the counter through more than a full cycle of up steps and then down steps, checking `pos` after every step. This exposes a design that swaps the direction, counts twice per step or skips the wrap; a wrong wrap detector would show up as a missing flag or the wrong flag. A one-strobe glitch and a change that never meets a strobe both target a filter that accepts a single sample or samples on every cycle. A double-phase jump catches a decoder that guesses a direction. Toggling `en` around a batch of steps catches a decoder that keeps a stale reference and fires a count when re-enabled.

// File: rtl/quad_pos_tracker.sv
module quad_pos_tracker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         in_i,
  input  logic         in_q,
  input  logic         stat_rd,
  output logic [W-1:0] pos,
  output logic [1:0]   stat,
  output logic         irq
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [1:0] smp, filt, base_q;
  logic       wrap_up, wrap_dn;
  wire  [1:0] raw = {in_i, in_q};

  function automatic logic [1:0] phase_idx(input logic [1:0] s);
    return {s[0], s[1] ^ s[0]};
  endfunction

  wire [1:0] delta   = phase_idx(filt) - phase_idx(base_q);
  wire       step_up = en && (delta == 2'd1);
  wire       step_dn = en && (delta == 2'd3);

  assign wrap_up = step_up && (pos == TOP);
  assign wrap_dn = step_dn && (pos == '0);
  assign irq     = |stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp    <= '0;
      filt   <= '0;
      base_q <= '0;
      pos    <= '0;
      stat   <= '0;
    end else begin
      if (tick) begin
        smp <= raw;
        for (int b = 0; b < 2; b++)
          if (raw[b] == smp[b]) filt[b] <= raw[b];
      end
      base_q <= filt;
      if (step_up)      pos <= pos + 1'b1;
      else if (step_dn) pos <= pos - 1'b1;
      stat[0] <= (stat[0] & ~stat_rd) | wrap_up;
      stat[1] <= (stat[1] & ~stat_rd) | wrap_dn;
    end
  end
endmodule

module quad_pos_tracker_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         en,
  input logic         stat_rd,
  input logic [W-1:0] pos,
  input logic [1:0]   stat,
  input logic         irq
);
  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pos));
  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> (pos == $past(pos) + 1'b1) || (pos == $past(pos) - 1'b1));
  // R5
  move_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> $past(tick) == 1'b0 && $past(tick, 2) == 1'b0 ? 1'b0 : 1'b1);
  // R7
  up_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> ($past(pos) == {W{1'b1}}) && (pos == '0));
  // R7
  dn_wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> ($past(pos) == '0) && (pos == {W{1'b1}}));
  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && $stable(pos)) |=> !$rose(irq) && (stat == '0 || !$stable(pos) || $rose(|stat) || $past(!stat_rd)) );
endmodule

bind quad_pos_tracker quad_pos_tracker_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .stat_rd(stat_rd),
  .pos(pos), .stat(stat), .irq(irq)
);

// File: tb/quad_pos_tracker_tb.sv
module quad_pos_tracker_tb;
  logic clk = 0, rst_n = 0, tick = 0, en = 1, in_i = 0, in_q = 0, stat_rd = 0;
  logic [7:0] pos;
  logic [1:0] stat;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_pos = 0;
  logic [1:0] m_base = 0, m_stat = 0;

  quad_pos_tracker u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .en(en),
    .in_i(in_i), .in_q(in_q), .stat_rd(stat_rd), .pos(pos), .stat(stat), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  function automatic int gidx(input logic [1:0] s);
    return {s[0], s[1] ^ s[0]};
  endfunction

  task automatic move(input logic [1:0] s);
    int d;
    {in_i, in_q} = s;
    strobe();
    strobe();
    @(negedge clk);
    @(negedge clk);
    d = (gidx(s) - gidx(m_base)) & 3;
    if (en && d == 1) begin
      if (m_pos == 8'hFF) m_stat[0] = 1;
      m_pos = m_pos + 1;
    end else if (en && d == 3) begin
      if (m_pos == 8'h00) m_stat[1] = 1;
      m_pos = m_pos - 1;
    end
    m_base = s;
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] s);
    case (s) 2'b00: return 2'b10; 2'b10: return 2'b11; 2'b11: return 2'b01; default: return 2'b00; endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] s);
    case (s) 2'b00: return 2'b01; 2'b01: return 2'b11; 2'b11: return 2'b10; default: return 2'b00; endcase
  endfunction

  task automatic read_stat();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
    m_stat = 0;
    chk(stat == 2'b00 && irq == 0, "R8 clear on read", {stat, irq}, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pos == 0, "R1 pos", pos, 0);
    chk(stat == 0, "R1 stat", stat, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 forward sweep through an upward wrap
    for (int k = 0; k < 260; k++) begin
      move(fwd(m_base));
      chk(pos == m_pos, "R2 up step", pos, m_pos);
    end
    chk(stat == 2'b01, "R7 up wrap flag", stat, 1);
    chk(irq == 1, "R7 irq on up wrap", irq, 1);
    read_stat();

    // R3 reverse sweep through a downward wrap
    for (int k = 0; k < 260; k++) begin
      move(rev(m_base));
      chk(pos == m_pos, "R3 down step", pos, m_pos);
    end
    chk(stat == 2'b10, "R7 down wrap flag", stat, 2);
    chk(irq == 1, "R7 irq on down wrap", irq, 1);
    read_stat();

    // R4 single-sample glitch
    begin
      logic [1:0] keep = m_base;
      {in_i, in_q} = fwd(keep);
      strobe();
      {in_i, in_q} = keep;
      strobe();
      strobe();
      repeat (3) @(negedge clk);
      chk(pos == m_pos, "R4 glitch ignored", pos, m_pos);
    end

    // R5 change between strobes
    begin
      logic [1:0] keep = m_base;
      {in_i, in_q} = fwd(keep);
      repeat (6) @(negedge clk);
      {in_i, in_q} = keep;
      strobe();
      strobe();
      repeat (3) @(negedge clk);
      chk(pos == m_pos, "R5 no strobe no count", pos, m_pos);
    end

    // R6 both phases jump
    move(~m_base);
    chk(pos == m_pos, "R6 illegal jump", pos, m_pos);
    move(fwd(m_base));
    chk(pos == m_pos, "R6 new reference", pos, m_pos);

    // R9 disable window
    @(negedge clk) en = 0;
    repeat (2) @(negedge clk);
    chk(pos == m_pos, "R9 enter disable", pos, m_pos);
    for (int k = 0; k < 5; k++) move(fwd(m_base));
    chk(pos == m_pos, "R9 held while off", pos, m_pos);
    @(negedge clk) en = 1;
    repeat (3) @(negedge clk);
    chk(pos == m_pos, "R9 leave disable", pos, m_pos);
    move(rev(m_base));
    chk(pos == m_pos, "R9 first step after enable", pos, m_pos);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule